// File: doc/BRIEF.md
# Time-Stamp Ordering Buffer

This block gathers hit records that come in on several input channels in no particular time order. Each record carries a beam-crossing time stamp. The block sorts the records simply by where it stores them. The time stamp selects a bucket in an on-chip random-access memory, and each bucket keeps its hits in arrival order behind a small per-bucket counter. No comparison network is involved.

A read engine walks the buckets in time-stamp order. It opens a bucket only once the externally supplied current time stamp is a configured number of units past it, so that every hit for that crossing is taken to have arrived. A non-empty bucket leaves the block as one event: a single header word that carries the time stamp, then the stored hits one per cycle. Because the stamp is sent once per event and not once per hit, the output stream is narrower than the input. Events are dealt to the output destinations in turn. After readout a bucket is emptied, so the time-stamp space can wrap around.

Top module: `tso_order_buf`

## Requirements
- R1: While reset is low and in the cycles that follow it, before any bucket has aged, no bit of `out_vld` is set.
- R2: All accepted hits that carry the same time stamp leave in one event. The event opens with a header word: `out_sof`=1, with the time stamp zero-extended in `out_word`.
- R3: A bucket is read only when (`cur_ts` − stamp) mod 2^TSW is at least DELAY. Buckets are visited in increasing time-stamp order.
- R4: After the header, an event carries its hits in arrival order, one word per cycle, with no gap and to the same destination. `out_eof`=1 marks the last hit.
- R5: A bucket with no hits produces no output, and it does not move the destination pointer.
- R6: Events go to the destinations in rotating order 0, 1, …, NDST−1, 0. The destination of a word is the index of the single set bit of `out_vld`.
- R7: A bucket holds at most DEPTH hits. Further hits to a full bucket are dropped and set `out_ovf`=1 on that event's header. The header shows `out_ovf`=0 when nothing was dropped.
- R8: When several channels present an acceptable hit in the same cycle, the lowest channel index is stored and the others are discarded.
- R9: A hit is accepted only if (`cur_ts` − its stamp) mod 2^TSW is below DELAY. Late hits and hits stamped in the future are discarded.
- R10: A bucket is emptied when its event ends, so a later reuse of the same stamp after wrap-around carries only the new hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | NCH | Per-channel hit valid |
| in_data | input | NCH*DW | Per-channel hit payload, channel k in bits [k*DW +: DW] |
| in_ts | input | NCH*TSW | Per-channel hit time stamp, channel k in bits [k*TSW +: TSW] |
| cur_ts | input | TSW | Current time-stamp counter |
| out_vld | output | NDST | One-hot destination strobe for the output word |
| out_sof | output | 1 | Word is an event header |
| out_eof | output | 1 | Word is the last hit of an event |
| out_ovf | output | 1 | On a header: the bucket dropped hits |
| out_word | output | DW | Header time stamp or hit payload |

## Verification
Storing a new hit and draining an aged bucket happen in the same cycles. Arbitration among channels that collide in one cycle also coincides with readout, as does the rejection of late hits. The bench drives three channels at once with stamps spread over fresh, late and future ages, while `cur_ts` keeps advancing and the read engine empties buckets. A reference model applies the acceptance, priority and capacity rules as each hit is presented. Every output event is compared word by word against the model's bucket, and the model bucket is cleared when its last word is seen. Running long enough to wrap the stamp space several times shows that emptied buckets start clean.

// File: rtl/tso_pkg.sv
package tso_pkg;
   typedef enum logic [0:0] {RD_SCAN, RD_BODY} rd_state_e;
endpackage

// File: rtl/tso_arbiter.sv
// Fixed-priority grant: lowest index wins (R8).
module tso_arbiter #(
   parameter int NCH = 3
) (
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] gnt
);
   logic [NCH-1:0] blocked;
   assign blocked[0] = 1'b0;
   assign gnt[0]     = req[0];
   for (genvar i = 1; i < NCH; i++) begin : g_prio
      assign blocked[i] = blocked[i-1] | req[i-1];
      assign gnt[i]     = req[i] & ~blocked[i];
   end
endmodule

// File: rtl/tso_bucket_store.sv
// Bucket memory addressed by time stamp, with per-bucket fill count and drop flag.
module tso_bucket_store #(
   parameter int TSW   = 7,
   parameter int DEPTH = 16,
   parameter int DW    = 16,
   localparam int NB   = 1 << TSW,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = IW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [TSW-1:0] wr_ts,
   input  logic [DW-1:0]  wr_data,
   input  logic [TSW-1:0] rd_ts,
   input  logic [IW-1:0]  rd_idx,
   input  logic           clr,
   output logic [DW-1:0]  rd_word,
   output logic [CW-1:0]  rd_cnt,
   output logic           rd_ovf
);
   logic [DW-1:0] mem [NB*DEPTH];
   logic [CW-1:0] fill [NB];
   logic [NB-1:0] drop;
   logic          full_w;

   assign full_w  = (fill[wr_ts] == CW'(DEPTH));
   assign rd_word = mem[{rd_ts, rd_idx}];
   assign rd_cnt  = fill[rd_ts];
   assign rd_ovf  = drop[rd_ts];

   always_ff @(posedge clk) begin
      if (wr_en && !full_w)
         mem[{wr_ts, fill[wr_ts][IW-1:0]}] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) fill[b] <= '0;
         drop <= '0;
      end else begin
         if (wr_en) begin
            if (full_w) drop[wr_ts] <= 1'b1;          // R7
            else        fill[wr_ts] <= fill[wr_ts] + 1'b1;
         end
         if (clr) begin                               // R10
            fill[rd_ts] <= '0;
            drop[rd_ts] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tso_readout.sv
// Walks buckets in stamp order and emits one event per non-empty aged bucket.
module tso_readout
   import tso_pkg::*;
#(
   parameter int TSW   = 7,
   parameter int DEPTH = 16,
   parameter int DW    = 16,
   parameter int NDST  = 8,
   parameter int DELAY = 4,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = IW + 1,
   localparam int DSTW = $clog2(NDST)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TSW-1:0]  cur_ts,
   input  logic [DW-1:0]   rd_word,
   input  logic [CW-1:0]   rd_cnt,
   input  logic            rd_ovf,
   output logic [TSW-1:0]  rd_ts,
   output logic [IW-1:0]   rd_idx,
   output logic            clr,
   output logic [NDST-1:0] out_vld,
   output logic            out_sof,
   output logic            out_eof,
   output logic            out_ovf,
   output logic [DW-1:0]   out_word
);
   rd_state_e     state;
   logic [DSTW-1:0] rot;
   logic [TSW-1:0]  age;
   logic            aged, last;

   assign age  = cur_ts - rd_ts;
   assign aged = (age >= TSW'(DELAY));                // R3
   assign last = ((CW'(rd_idx) + 1'b1) == rd_cnt);
   assign clr  = (state == RD_BODY) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RD_SCAN;
         rd_ts    <= '0;
         rd_idx   <= '0;
         rot      <= '0;
         out_vld  <= '0;
         out_sof  <= 1'b0;
         out_eof  <= 1'b0;
         out_ovf  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= '0;
         out_sof <= 1'b0;
         out_eof <= 1'b0;
         out_ovf <= 1'b0;
         case (state)
            RD_SCAN: if (aged) begin
               if (rd_cnt == '0) begin
                  rd_ts <= rd_ts + 1'b1;              // R5: skip, rot unchanged
               end else begin
                  out_vld  <= NDST'(1) << rot;
                  out_sof  <= 1'b1;
                  out_ovf  <= rd_ovf;
                  out_word <= DW'(rd_ts);
                  rd_idx   <= '0;
                  state    <= RD_BODY;
               end
            end
            RD_BODY: begin
               out_vld  <= NDST'(1) << rot;
               out_word <= rd_word;
               out_eof  <= last;
               if (last) begin
                  rd_ts <= rd_ts + 1'b1;
                  rot   <= (rot == DSTW'(NDST-1)) ? '0 : rot + 1'b1;  // R6
                  state <= RD_SCAN;
               end else begin
                  rd_idx <= rd_idx + 1'b1;
               end
            end
            default: state <= RD_SCAN;
         endcase
      end
   end
endmodule

// File: rtl/tso_order_buf.sv
module tso_order_buf #(
   parameter int NCH   = 3,
   parameter int TSW   = 7,
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   parameter int NDST  = 8,
   parameter int DELAY = 4,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = IW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCH-1:0]     in_vld,
   input  logic [NCH*DW-1:0]  in_data,
   input  logic [NCH*TSW-1:0] in_ts,
   input  logic [TSW-1:0]     cur_ts,
   output logic [NDST-1:0]    out_vld,
   output logic               out_sof,
   output logic               out_eof,
   output logic               out_ovf,
   output logic [DW-1:0]      out_word
);
   if (DELAY < 1 || DELAY >= (1 << TSW)) begin : g_bad_delay
      $error("DELAY must lie in 1 .. 2**TSW-1");
   end
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DW < TSW) begin : g_bad_dw
      $error("DW must hold a time stamp");
   end
   if (NDST < 2 || NCH < 1) begin : g_bad_cnt
      $error("NDST >= 2 and NCH >= 1 required");
   end

   logic [NCH-1:0] req, gnt;
   logic           wr_en;
   logic [TSW-1:0] wr_ts, rd_ts;
   logic [DW-1:0]  wr_data, rd_word;
   logic [IW-1:0]  rd_idx;
   logic [CW-1:0]  rd_cnt;
   logic           rd_ovf, clr;

   // R9: only stamps younger than DELAY may compete for the write port
   for (genvar k = 0; k < NCH; k++) begin : g_fresh
      logic [TSW-1:0] age_k;
      assign age_k  = cur_ts - in_ts[k*TSW +: TSW];
      assign req[k] = in_vld[k] && (age_k < TSW'(DELAY));
   end

   tso_arbiter #(.NCH(NCH)) u_arb (.req(req), .gnt(gnt));

   always_comb begin
      wr_data = '0;
      wr_ts   = '0;
      for (int k = 0; k < NCH; k++) begin
         if (gnt[k]) begin
            wr_data = wr_data | in_data[k*DW +: DW];
            wr_ts   = wr_ts   | in_ts[k*TSW +: TSW];
         end
      end
   end
   assign wr_en = |gnt;

   tso_bucket_store #(.TSW(TSW), .DEPTH(DEPTH), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ts(wr_ts), .wr_data(wr_data),
      .rd_ts(rd_ts), .rd_idx(rd_idx), .clr(clr),
      .rd_word(rd_word), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf)
   );

   tso_readout #(.TSW(TSW), .DEPTH(DEPTH), .DW(DW), .NDST(NDST), .DELAY(DELAY)) u_rd (
      .clk(clk), .rst_n(rst_n), .cur_ts(cur_ts),
      .rd_word(rd_word), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf),
      .rd_ts(rd_ts), .rd_idx(rd_idx), .clr(clr),
      .out_vld(out_vld), .out_sof(out_sof), .out_eof(out_eof),
      .out_ovf(out_ovf), .out_word(out_word)
   );
endmodule

// File: rtl/tso_order_buf_chk.sv
module tso_order_buf_chk #(
   parameter int TSW   = 7,
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   parameter int NDST  = 8,
   parameter int DELAY = 4,
   localparam int BW   = $clog2(DEPTH) + 2,
   localparam int DSTW = $clog2(NDST)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [TSW-1:0]  cur_ts,
   input logic [NDST-1:0] out_vld,
   input logic            out_sof,
   input logic            out_eof,
   input logic [DW-1:0]   out_word
);
   logic [TSW-1:0]  hdr_age;
   logic [BW-1:0]   body_n;
   logic [DSTW-1:0] next_dst;
   logic            any;

   assign any     = |out_vld;
   assign hdr_age = cur_ts - out_word[TSW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         body_n   <= '0;
         next_dst <= '0;
      end else if (any) begin
         if (out_sof) begin
            body_n   <= '0;
            next_dst <= (next_dst == DSTW'(NDST-1)) ? '0 : next_dst + 1'b1;
         end else begin
            body_n <= body_n + 1'b1;
         end
      end
   end

   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(out_vld));
   a_r6_rotation: assert property (@(posedge clk) disable iff (!rst_n)
      (any && out_sof) |-> (out_vld == (NDST'(1) << next_dst)));
   a_r3_aged_header: assert property (@(posedge clk) disable iff (!rst_n)
      (any && out_sof) |-> (hdr_age >= TSW'(DELAY)));
   a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (any && !out_eof) |=> (|out_vld && !out_sof && out_vld == $past(out_vld)));
   a_r4_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (any && out_eof) |=> (!(|out_vld) || out_sof));
   a_r4_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eof) |-> any);
   a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
      (any && !out_sof) |-> (body_n < BW'(DEPTH)));
endmodule

bind tso_order_buf tso_order_buf_chk #(
   .TSW(TSW), .DW(DW), .DEPTH(DEPTH), .NDST(NDST), .DELAY(DELAY)
) u_chk (.*);

// File: tb/tb_tso_order_buf.sv
module tb_tso_order_buf;
   localparam int NCH = 3, TSW = 4, DW = 8, DEPTH = 4, NDST = 3, DELAY = 3;
   localparam int NB = 1 << TSW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic [NCH-1:0]     in_vld;
   logic [NCH*DW-1:0]  in_data;
   logic [NCH*TSW-1:0] in_ts;
   logic [TSW-1:0]     cur_ts;
   logic [NDST-1:0]    out_vld;
   logic               out_sof, out_eof, out_ovf;
   logic [DW-1:0]      out_word;

   tso_order_buf #(.NCH(NCH), .TSW(TSW), .DW(DW), .DEPTH(DEPTH), .NDST(NDST), .DELAY(DELAY)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_ts(in_ts),
      .cur_ts(cur_ts), .out_vld(out_vld), .out_sof(out_sof), .out_eof(out_eof),
      .out_ovf(out_ovf), .out_word(out_word)
   );

   int nchk = 0, nbad = 0;
   int m_cnt [NB];
   logic [DW-1:0] m_dat [NB][DEPTH];
   bit  m_ovf [NB];
   int  m_rot = 0, events = 0, evt_ts = 0, evt_n = 0;
   bit  in_evt = 0, done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // output monitor against the reference model
   always @(negedge clk) begin
      if (rst_n && |out_vld) begin
         int dst;
         dst = 0;
         for (int d = 0; d < NDST; d++) if (out_vld[d]) dst = d;
         if (out_sof) begin
            int ts, age;
            ts  = int'(out_word[TSW-1:0]);
            age = int'(4'(cur_ts - out_word[TSW-1:0]));
            chk(!in_evt, "R4 header inside event", 1, 0);
            chk(m_cnt[ts] > 0, "R2 R5 header only for non-empty bucket", m_cnt[ts], 1);
            chk(out_word[DW-1:TSW] == '0, "R2 header zero-extended", int'(out_word), ts);
            chk(age >= DELAY, "R3 bucket aged", age, DELAY);
            chk(dst == m_rot, "R6 destination", dst, m_rot);
            chk(out_ovf == m_ovf[ts], "R7 overflow flag", int'(out_ovf), int'(m_ovf[ts]));
            in_evt = 1; evt_ts = ts; evt_n = 0;
         end else begin
            chk(in_evt, "R4 hit outside event", 0, 1);
            if (evt_n < DEPTH)
               chk(out_word == m_dat[evt_ts][evt_n], "R4 R8 R9 R10 hit data",
                   int'(out_word), int'(m_dat[evt_ts][evt_n]));
            evt_n++;
            chk(out_eof == (evt_n == m_cnt[evt_ts]), "R4 last flag", int'(out_eof), int'(evt_n == m_cnt[evt_ts]));
            if (out_eof) begin
               m_cnt[evt_ts] = 0;
               m_ovf[evt_ts] = 0;
               m_rot = (m_rot + 1) % NDST;
               in_evt = 0;
               events++;
            end
         end
      end
   end

   // model of acceptance (R9), priority (R8) and capacity (R7)
   task automatic model_apply();
      bit taken;
      taken = 0;
      for (int k = 0; k < NCH; k++) begin
         logic [TSW-1:0] ts, age;
         ts  = in_ts[k*TSW +: TSW];
         age = cur_ts - ts;
         if (in_vld[k] && int'(age) < DELAY && !taken) begin
            taken = 1;
            if (m_cnt[ts] < DEPTH) begin
               m_dat[ts][m_cnt[ts]] = in_data[k*DW +: DW];
               m_cnt[ts]++;
            end else begin
               m_ovf[ts] = 1;
            end
         end
      end
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_ovf[b] = 0; end
      rst_n = 1'b0; in_vld = '0; in_data = '0; in_ts = '0; cur_ts = '0;
      repeat (3) @(negedge clk);
      chk(out_vld == '0, "R1 quiet in reset", int'(out_vld), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(out_vld == '0, "R1 quiet after reset", int'(out_vld), 0);
      for (int t = 0; t < 64; t++) begin
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c == 0) cur_ts = TSW'(t);
            for (int k = 0; k < NCH; k++) begin
               int age;
               bit v;
               v   = (t >= 5) && (t < 52) && (t % 7 != 3) && (c <= t % 6) && ((c + k + t) % 3 != 0);
               age = (2 * c + k + t) % 6;
               in_vld[k] = v;
               in_ts[k*TSW +: TSW] = (age == 5) ? TSW'(t + 1) : TSW'(t - age);
               in_data[k*DW +: DW] = DW'(t * 16 + c * 3 + k * 5 + 1);
            end
            model_apply();
         end
      end
      @(negedge clk);
      in_vld = '0;
      repeat (40) @(negedge clk);
      for (int b = 0; b < NB; b++)
         chk(m_cnt[b] == 0, "R2 R10 every stored bucket drained", m_cnt[b], 0);
      chk(events > 10, "R2 events produced", events, 11);
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nbad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule